// File: doc/BRIEF.md
# SCSI Interface Status and Interrupt Register Bank

This block is the register file of a small SCSI interface controller. A host reaches it over a 16-bit register bus with byte addresses, one read or write per cycle. It stores a handful of configuration words: diagnostics, control, bus ID, target select, a data byte, a transfer mode and a command word. It also keeps two status words. The connection status word reports bus-level events and the transfer status word reports data-movement events. In each status word some bits are cleared by writing a one, some keep their value whatever software writes, and the rest can be written freely.

A sequencer outside the block raises status bits with one-cycle set pulses. It also supplies a tick that steps a 3-bit phase counter held in the low bits of the transfer status word.

Two summary flags are derived continuously. A connection flag is built from six connection events and a data flag from four transfer events. Both flags appear in the top two bits of both status words. A single level interrupt output goes high while the control word's enable bit is set and either flag is set.

Top module: `scsi_stat_regs`

## Requirements
- R1: After reset every register reads 0x0000 and `irq` is low.
- R2: Registers decode at byte offsets 0x00 diag, 0x0C control, 0x10 ID, 0x14 target select, 0x18 select detect, 0x20 data, 0x24 transfer mode, 0x48 connection status, 0x4C transfer status, 0x50 command and 0x54 diag control. A write whose address has bit 1 or bit 0 set changes nothing. A read of an unmapped offset returns 0.
- R3: The ID and target select registers store only wdata[2:0]. The data register stores only wdata[7:0]. The transfer mode register stores only wdata[1:0], and `xfer_sync` is high whenever that field is nonzero. The diag, control, command and diag control registers store all 16 bits.
- R4: The select detect register ignores writes and always reads 0x0000.
- R5: On a write to connection status, each of bits 13, 12, 11, 9, 8, 7 and 3 is cleared when the written bit is 1. Bits in mask 0x3BF7 that are not clearable keep their value. Bits 10 and 3 take the written value, so bit 3 always ends at 0.
- R6: On a write to transfer status, each of bits 13, 11, 10, 4 and 3 is cleared when the written bit is 1. Bits in mask 0x0C17 that are not clearable keep their value. The remaining bits of 13:0 take the written value.
- R7: A set pulse on `conn_set[i]` or `xfer_set[i]` makes status bit i read 1 from the next cycle on. This holds even when a write in the same cycle would clear that bit.
- R8: The connection flag is the OR of connection status bits 13 (bus reset), 12 (bus error), 11 (odd byte count), 9 (buffer), 8 (link done) and 7 (state change).
- R9: The data flag is the OR of transfer status bits 4 (phase mismatch), 11 (input full), 12 (transmit empty) and 13 (transfer done).
- R10: Both status registers read the connection flag at bit 15 and the data flag at bit 14, and both follow the current status bits in the same cycle.
- R11: `irq` is high exactly when control bit 0 is 1 and either flag is 1.
- R12: Each `tick` pulse advances transfer status bits 2:0 modulo 8, including in a cycle that writes that register. `xfer_set[2:0]` has no effect and bits 13:3 are not touched by the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| conn_set | input | 14 | Set pulses for connection status bits 13:0 |
| xfer_set | input | 14 | Set pulses for transfer status bits 13:0 |
| tick | input | 1 | Advances the transfer phase counter |
| xfer_sync | output | 1 | Transfer mode field is nonzero |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can land in the same cycle. A sequencer set pulse can arrive together with a software write-one-to-clear of the same status bit, and a phase tick can arrive together with a software write of the transfer status word. The bench drives each pair in a single clock cycle. It reads the register back on the following cycle and expects the set bit to be 1 and the counter to be one step ahead. Sweeps of set patterns and write patterns over both status words are checked against masks computed in the bench. Those sweeps also check the mirrored flags and `irq` after every step.

// File: rtl/scsi_stat_pkg.sv
package scsi_stat_pkg;

    localparam int DW     = 16;
    localparam int AW     = 8;
    localparam int SW     = 14;
    localparam int PH_W   = 3;
    localparam int NCFG   = 8;
    localparam int IE_BIT = 0;

    typedef enum logic [AW-1:0] {
        OFF_DIAG    = 8'h00,
        OFF_CTRL    = 8'h0C,
        OFF_ID      = 8'h10,
        OFF_TSEL    = 8'h14,
        OFF_SELDET  = 8'h18,
        OFF_DATA    = 8'h20,
        OFF_MODE    = 8'h24,
        OFF_CONN    = 8'h48,
        OFF_XFER    = 8'h4C,
        OFF_CMD     = 8'h50,
        OFF_DIAGCTL = 8'h54
    } reg_off_e;

    // index of each plain configuration register in the bank
    localparam int CFG_DIAG    = 0;
    localparam int CFG_CTRL    = 1;
    localparam int CFG_ID      = 2;
    localparam int CFG_TSEL    = 3;
    localparam int CFG_DATA    = 4;
    localparam int CFG_MODE    = 5;
    localparam int CFG_CMD     = 6;
    localparam int CFG_DIAGCTL = 7;

    localparam logic [AW-1:0] CFG_OFF [NCFG] = '{
        OFF_DIAG, OFF_CTRL, OFF_ID, OFF_TSEL,
        OFF_DATA, OFF_MODE, OFF_CMD, OFF_DIAGCTL
    };

    localparam logic [DW-1:0] CFG_KEEP [NCFG] = '{
        16'hFFFF, 16'hFFFF, 16'h0007, 16'h0007,
        16'h00FF, 16'h0003, 16'hFFFF, 16'hFFFF
    };

    // connection status: clear-on-one and protected bit sets
    localparam logic [SW-1:0] CONN_CLR = 14'h3B88;
    localparam logic [SW-1:0] CONN_RO  = 14'h3BF7;
    localparam logic [SW-1:0] CONN_GRP = 14'h3B80;

    // transfer status
    localparam logic [SW-1:0] XFER_CLR = 14'h2C18;
    localparam logic [SW-1:0] XFER_RO  = 14'h0C17;
    localparam logic [SW-1:0] XFER_GRP = 14'h3810;

    typedef struct packed {
        logic          valid;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic conn;
        logic data;
    } summary_t;

    function automatic logic aligned(input logic [AW-1:0] a);
        return a[1:0] == 2'b00;
    endfunction

endpackage

// File: rtl/scsi_cfg_reg.sv
module scsi_cfg_reg #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wdata & KEEP;
    end

    // R3
    keep_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == ($past(wdata) & KEEP)));

endmodule

// File: rtl/scsi_status_reg.sv
module scsi_status_reg #(
    parameter int           W        = 14,
    parameter logic [W-1:0] CLR_MASK = '0,
    parameter logic [W-1:0] RO_MASK  = '0,
    parameter int           CNT_BITS = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_in,
    input  logic         tick,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] CNT_MASK = (CNT_BITS > 0) ? W'((1 << CNT_BITS) - 1) : '0;
    localparam logic [W-1:0] SET_MASK = ~CNT_MASK;
    localparam logic [W-1:0] KEEP     = RO_MASK & ~CLR_MASK & ~CNT_MASK;
    localparam logic [W-1:0] FREE     = ~RO_MASK & ~CLR_MASK;

    logic [W-1:0] sw_next;
    logic [W-1:0] hw_next;
    logic [W-1:0] cnt_inc;
    logic [W-1:0] d;

    always_comb begin
        if (wr_en)
            sw_next = (q & RO_MASK & ~(wdata & CLR_MASK)) | (wdata & FREE);
        else
            sw_next = q;
        // hardware set wins over a software clear in the same cycle
        hw_next = sw_next | (set_in & SET_MASK);
        cnt_inc = ((q & CNT_MASK) + W'(1)) & CNT_MASK;
        if (tick && (CNT_BITS > 0))
            d = (hw_next & ~CNT_MASK) | cnt_inc;
        else
            d = hw_next;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(set_in & SET_MASK)) |=> ((q & $past(set_in & SET_MASK)) == $past(set_in & SET_MASK)));

    // R5 R6
    ro_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(|(set_in & SET_MASK))) |=> ((q & KEEP) == $past(q & KEEP)));

    generate
        if (CNT_BITS > 0) begin : g_phase
            // R12
            phase_step_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> ((q & CNT_MASK) == (($past(q & CNT_MASK) + W'(1)) & CNT_MASK)));
        end
    endgenerate

endmodule

// File: rtl/scsi_summary.sv
module scsi_summary
    import scsi_stat_pkg::*;
(
    input  logic [SW-1:0] conn_q,
    input  logic [SW-1:0] xfer_q,
    input  logic          irq_en,
    output summary_t      flags,
    output logic          irq
);

    always_comb begin
        flags.conn = |(conn_q & CONN_GRP);
        flags.data = |(xfer_q & XFER_GRP);
        irq        = irq_en & (flags.conn | flags.data);
    end

endmodule

// File: rtl/scsi_stat_regs.sv
module scsi_stat_regs
    import scsi_stat_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [SW-1:0] conn_set,
    input  logic [SW-1:0] xfer_set,
    input  logic          tick,
    output logic          xfer_sync,
    output logic          irq
);

    bus_req_t      req;
    logic          wr_ok;
    logic [DW-1:0] cfg_q [NCFG];
    logic [SW-1:0] conn_q;
    logic [SW-1:0] xfer_q;
    summary_t      flags;

    assign req   = '{valid: bus_valid, write: bus_write, addr: bus_addr, wdata: bus_wdata};
    assign wr_ok = req.valid && req.write && aligned(req.addr);

    generate
        for (genvar k = 0; k < NCFG; k++) begin : g_cfg
            scsi_cfg_reg #(.W(DW), .KEEP(CFG_KEEP[k])) u_cfg (
                .clk   (clk),
                .rst   (rst),
                .wr_en (wr_ok && (req.addr == CFG_OFF[k])),
                .wdata (req.wdata),
                .q     (cfg_q[k])
            );
        end
    endgenerate

    scsi_status_reg #(
        .W(SW), .CLR_MASK(CONN_CLR), .RO_MASK(CONN_RO), .CNT_BITS(0)
    ) u_conn (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok && (req.addr == OFF_CONN)),
        .wdata  (req.wdata[SW-1:0]),
        .set_in (conn_set),
        .tick   (1'b0),
        .q      (conn_q)
    );

    scsi_status_reg #(
        .W(SW), .CLR_MASK(XFER_CLR), .RO_MASK(XFER_RO), .CNT_BITS(PH_W)
    ) u_xfer (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok && (req.addr == OFF_XFER)),
        .wdata  (req.wdata[SW-1:0]),
        .set_in (xfer_set),
        .tick   (tick),
        .q      (xfer_q)
    );

    scsi_summary u_sum (
        .conn_q (conn_q),
        .xfer_q (xfer_q),
        .irq_en (cfg_q[CFG_CTRL][IE_BIT]),
        .flags  (flags),
        .irq    (irq)
    );

    assign xfer_sync = |cfg_q[CFG_MODE];

    always_comb begin
        bus_rdata = '0;
        if (req.valid && !req.write) begin
            for (int k = 0; k < NCFG; k++)
                if (req.addr == CFG_OFF[k])
                    bus_rdata = cfg_q[k];
            if (req.addr == OFF_CONN)
                bus_rdata = {flags.conn, flags.data, conn_q};
            if (req.addr == OFF_XFER)
                bus_rdata = {flags.conn, flags.data, xfer_q};
        end
    end

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> cfg_q[CFG_CTRL][IE_BIT]);

    // R2
    misaligned_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && (bus_addr[1:0] != 2'b00))
            |=> ($stable(cfg_q[CFG_ID]) && $stable(cfg_q[CFG_CTRL]) && $stable(cfg_q[CFG_DATA])));

    // R8
    conn_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|(conn_set & CONN_GRP)) |=> flags.conn);

endmodule

// File: tb/scsi_stat_regs_test.sv
`timescale 1ns/1ps
module scsi_stat_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [13:0] conn_set = '0;
    logic [13:0] xfer_set = '0;
    logic        tick = 1'b0;
    logic        xfer_sync;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model
    logic [13:0] m_conn = '0;
    logic [13:0] m_xfer = '0;
    logic [15:0] m_ctrl = '0;

    always #2.5 clk = ~clk;

    scsi_stat_regs uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conn_set(conn_set), .xfer_set(xfer_set), .tick(tick),
        .xfer_sync(xfer_sync), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle with optional sequencer activity; model updated per requirements
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                       input logic [13:0] cs, input logic [13:0] xs, input logic tk);
        @(negedge clk);
        bus_valid = wr; bus_write = wr; bus_addr = a; bus_wdata = wd;
        conn_set = cs; xfer_set = xs; tick = tk;
        if (wr && a[1:0] == 2'b00) begin
            if (a == 8'h48)
                m_conn = (m_conn & 14'h3BF7 & ~(wd[13:0] & 14'h3B88)) | (wd[13:0] & ~14'h3BF7 & ~14'h3B88);
            if (a == 8'h4C)
                m_xfer = (m_xfer & 14'h0C17 & ~(wd[13:0] & 14'h2C18)) | (wd[13:0] & ~14'h0C17 & ~14'h2C18);
            if (a == 8'h0C)
                m_ctrl = wd;
        end
        m_conn = m_conn | cs;
        m_xfer = m_xfer | (xs & 14'h3FF8);
        if (tk)
            m_xfer = (m_xfer & 14'h3FF8) | ((m_xfer + 14'd1) & 14'h0007);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; conn_set = '0; xfer_set = '0; tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] wd);
        cyc(1'b1, a, wd, '0, '0, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_valid = 1'b0;
        #0.5;
    endtask

    task automatic check_status(input string tag);
        logic [15:0] v;
        logic fc, fd;
        fc = |(m_conn & 14'h3B80);
        fd = |(m_xfer & 14'h3810);
        rd(8'h48, v);
        chk({tag, " R5 R8 R10 conn"}, v, {fc, fd, m_conn});
        rd(8'h4C, v);
        chk({tag, " R6 R9 R10 xfer"}, v, {fc, fd, m_xfer});
        chk({tag, " R11 irq"}, {15'd0, irq}, {15'd0, m_ctrl[0] & (fc | fd)});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0] offs [11];
        offs = '{8'h00, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h48, 8'h4C, 8'h50, 8'h54};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 11; i++) begin
            rd(offs[i], v);
            chk("R1 reset value", v, 16'h0000);
        end
        chk("R1 irq after reset", {15'd0, irq}, 16'h0000);

        // R3: field widths on plain registers
        for (int i = 0; i < 64; i++) begin
            logic [15:0] p;
            p = 16'(i * 1031) ^ 16'(i << 9) ^ 16'hA5C3;
            wr(8'h10, p); rd(8'h10, v); chk("R3 ID keeps 2:0", v, p & 16'h0007);
            wr(8'h14, p); rd(8'h14, v); chk("R3 target select keeps 2:0", v, p & 16'h0007);
            wr(8'h20, p); rd(8'h20, v); chk("R3 data keeps 7:0", v, p & 16'h00FF);
            wr(8'h24, p); rd(8'h24, v); chk("R3 mode keeps 1:0", v, p & 16'h0003);
            chk("R3 sync flag", {15'd0, xfer_sync}, {15'd0, (p[1:0] != 2'b00)});
            wr(8'h00, p); rd(8'h00, v); chk("R3 diag full", v, p);
            wr(8'h50, ~p); rd(8'h50, v); chk("R3 command full", v, ~p);
            wr(8'h54, p ^ 16'h0F0F); rd(8'h54, v); chk("R3 diag control full", v, p ^ 16'h0F0F);
        end

        // R4: select detect read-only
        wr(8'h18, 16'hFFFF);
        rd(8'h18, v); chk("R4 select detect write ignored", v, 16'h0000);

        // R2: misaligned writes and unmapped reads
        wr(8'h10, 16'h0005);
        wr(8'h11, 16'h0002); wr(8'h12, 16'h0003); wr(8'h13, 16'h0001);
        rd(8'h10, v); chk("R2 misaligned write ignored", v, 16'h0005);
        wr(8'h0D, 16'h0001);
        rd(8'h0C, v); chk("R2 misaligned ctrl ignored", v, 16'h0000);
        rd(8'h30, v); chk("R2 unmapped read zero", v, 16'h0000);

        // R5: connection status bit sweep, then pattern sweep
        for (int b = 0; b < 14; b++) begin
            cyc(1'b0, 8'h00, 16'h0, 14'h3FFF, 14'h0, 1'b0);
            wr(8'h48, 16'(1 << b));
            check_status("R5 single bit");
        end
        for (int i = 0; i < 48; i++) begin
            cyc(1'b0, 8'h00, 16'h0, 14'(i * 677 + 3), 14'h0, 1'b0);
            wr(8'h48, 16'(i * 2311) ^ 16'h1C35);
            check_status("R5 pattern");
        end

        // R6: transfer status sweep (set on 2:0 ignored per R12)
        for (int b = 0; b < 14; b++) begin
            cyc(1'b0, 8'h00, 16'h0, 14'h0, 14'h3FFF, 1'b0);
            wr(8'h4C, 16'(1 << b));
            check_status("R6 single bit");
        end
        for (int i = 0; i < 48; i++) begin
            cyc(1'b0, 8'h00, 16'h0, 14'h0, 14'(i * 911 + 7), 1'b0);
            wr(8'h4C, 16'(i * 4099) ^ 16'h2A51);
            check_status("R6 pattern");
        end

        // R8 R9 R10 R11: each group bit alone, irq enabled and disabled
        for (int en = 0; en < 2; en++) begin
            wr(8'h0C, 16'(en));
            for (int b = 0; b < 14; b++) begin
                wr(8'h48, 16'h3B88);
                wr(8'h4C, 16'h2C18);
                check_status("R11 cleared");
                cyc(1'b0, 8'h00, 16'h0, 14'(1 << b), 14'h0, 1'b0);
                check_status("R8 conn bit");
                wr(8'h48, 16'h3B88);
                cyc(1'b0, 8'h00, 16'h0, 14'h0, 14'(1 << b), 1'b0);
                check_status("R9 xfer bit");
            end
        end

        // R7: set pulse and clearing write in the same cycle
        wr(8'h48, 16'h3B88);
        cyc(1'b1, 8'h48, 16'h0100, 14'h0100, 14'h0, 1'b0);
        rd(8'h48, v); chk("R7 conn set beats clear", v & 16'h0100, 16'h0100);
        check_status("R7 conn");
        wr(8'h4C, 16'h2C18);
        cyc(1'b1, 8'h4C, 16'h0800, 14'h0, 14'h0800, 1'b0);
        rd(8'h4C, v); chk("R7 xfer set beats clear", v & 16'h0800, 16'h0800);
        check_status("R7 xfer");

        // R12: phase counter
        for (int t = 0; t < 12; t++) begin
            cyc(1'b0, 8'h00, 16'h0, 14'h0, 14'h0007, 1'b1);
            check_status("R12 tick");
        end
        rd(8'h4C, v);
        cyc(1'b1, 8'h4C, 16'h0007, 14'h0, 14'h0, 1'b1);
        rd(8'h4C, bus_wdata);
        chk("R12 tick during write", bus_wdata & 16'h0007, (v + 16'd1) & 16'h0007);
        check_status("R12 tick with write");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule